// File: doc/BRIEF.md
# Self-Clocked Converter Frame Receiver

This block sits on the host side of a three-wire serial link to a data converter that generates its own serial clock. Chip select is held active at all times, so the host never drives the clock line. The host only watches the remote clock and the converter's data output. Both lines are brought into the fast system clock domain through synchronisers, and every edge of the remote clock is detected there.

While the converter is busy, both lines rest high. When the clock and data lines both drop low, the result is ready. At that moment the receiver takes a copy of the user's configuration word and starts a frame. During the frame it collects 24 result bits and shifts the 16 configuration bits back toward the converter. At the end of the frame it presents the word with either a valid strobe or an error strobe.

A frame that stalls with the clock low is abandoned after a programmable number of system cycles. The receiver then waits for the link to return to its busy state before it accepts the next frame.

Top module: `adcLinkRx`

## Requirements
- R1: During and right after reset, `dataWord` is 0, `resultValid`, `frameError` and `timeoutFlag` are 0, and `sdiOut` is 0.
- R2: When the receiver is waiting for a conversion and the synchronised clock and data lines are both low, a frame starts and `sdiOut` presents bit 15 (the MSB) of `cfgWord`.
- R3: The configuration bits go out MSB first. Each falling edge of the remote clock moves `sdiOut` to the next lower bit, so bit 15-k is on `sdiOut` at rising edge k (counting from 0). After all 16 bits have gone out, `sdiOut` is 0 and stays 0 through the conversion that follows.
- R4: The 24 frame bits are sampled on the synchronised rising edges of the remote clock, with frame bit 23 first. `dataWord` holds the full frame, with bit 23 in its MSB, from shortly after the 24th rising edge until the next frame completes.
- R5: After the 24th rising edge the frame is checked. If bit 23 (the end-of-conversion flag) and bit 22 (the fixed zero) are both 0, `resultValid` pulses for one cycle. Otherwise `frameError` pulses for one cycle and `resultValid` stays low.
- R6: The configuration word is captured when the frame starts. A change to `cfgWord` during a frame has no effect on the bits sent in that frame, and the new value is sent in the next frame.
- R7: If the remote clock stays low with no edge for `timeoutLimit` system cycles during a frame, `timeoutFlag` pulses once, the frame is dropped without any valid or error pulse, and `sdiOut` returns to 0. Low phases shorter than the limit never raise the flag.
- R8: After reset or a timeout, the receiver ignores the lines until it has seen both of them high. A low-low state before that point does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the remote serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | Serial clock driven by the converter |
| sdoIn | input | 1 | Serial data from the converter |
| cfgWord | input | 16 | Configuration word to send in the next frame |
| timeoutLimit | input | 16 | Number of system cycles the clock may stay low during a frame |
| sdiOut | output | 1 | Serial configuration data toward the converter |
| dataWord | output | 24 | Last complete received frame |
| resultValid | output | 1 | One-cycle strobe: the frame passed its checks |
| frameError | output | 1 | One-cycle strobe: the flag bits of the frame were wrong |
| timeoutFlag | output | 1 | One-cycle strobe: the frame stalled and was dropped |

## Verification
The converter model drives several kinds of result patterns:
- A walking one through all 22 payload positions, which tells a dropped or swapped bit apart from a shift that is off by one.
- All-zero and all-one payloads, plus a pseudo-random series, which expose stuck or inverted sampling.

For each pattern the model records the configuration bits it sees on every rising edge. These are compared with the word latched at the start of the frame, including a word that changes part-way through a frame.

Frames with a bad end-of-conversion bit, a bad fixed-zero bit, or both, separate the error path from the valid path. A stalled frame and a reset held with the lines low show whether the receiver waits correctly for the link to go idle.

// File: rtl/adcLinkPkg.sv
package adcLinkPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } linkState_t;

  typedef struct packed {
    logic loadCfg;
    logic shiftCfg;
    logic sampleBit;
    logic finishFrame;
    logic abortFrame;
  } linkStrobe_t;

endpackage

// File: rtl/adcLinkSync.sv
module adcLinkSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  input  logic [WIDTH-1:0] resetVal,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageReg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stageReg[s] <= resetVal;
        else       stageReg[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stageReg[s] <= resetVal;
        else       stageReg[s] <= stageReg[s-1];
      end
    end
  end

  assign syncOut = stageReg[STAGES-1];

endmodule

// File: rtl/adcLinkCtrl.sv
module adcLinkCtrl
  import adcLinkPkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int TIMEOUT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sckS,
  input  logic                 sdoS,
  input  logic                 sckRise,
  input  logic                 sckFall,
  input  logic [TIMEOUT_W-1:0] timeoutLimit,
  output linkStrobe_t          strobe,
  output logic                 timeoutFlag
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  linkState_t state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic [TIMEOUT_W-1:0] lowCnt;
  logic toExpire;

  // a low phase has lasted long enough once the next cycle would reach the limit
  assign toExpire = ({1'b0, lowCnt} + 1'b1) >= {1'b0, timeoutLimit};

  always_comb begin
    nextState = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (sckS && sdoS) nextState = ST_CONV;
      end
      ST_CONV: begin
        if (!sckS && !sdoS) begin
          strobe.loadCfg = 1'b1;
          nextState = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sckRise) begin
          strobe.sampleBit = 1'b1;
          if (bitCnt == LAST_BIT) begin
            strobe.finishFrame = 1'b1;
            nextState = ST_CONV;
          end
        end else if (sckFall) begin
          strobe.shiftCfg = 1'b1;
        end else if (!sckS && toExpire) begin
          strobe.abortFrame = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      lowCnt      <= '0;
      timeoutFlag <= 1'b0;
    end else begin
      state       <= nextState;
      timeoutFlag <= strobe.abortFrame;
      if (strobe.loadCfg || strobe.finishFrame || strobe.abortFrame)
        bitCnt <= '0;
      else if (strobe.sampleBit)
        bitCnt <= bitCnt + 1'b1;
      if (state != ST_SHIFT || sckS || sckRise || sckFall || strobe.abortFrame)
        lowCnt <= '0;
      else
        lowCnt <= lowCnt + 1'b1;
    end
  end

  p_bitcnt_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);

  p_timeout_from_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> $past(state) == ST_SHIFT);

  p_frame_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && $past(state) == ST_CONV) |-> $past(!sckS && !sdoS));

  p_idle_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && $past(state) == ST_IDLE) |-> $past(sckS && sdoS));

endmodule

// File: rtl/adcLinkDatapath.sv
module adcLinkDatapath
  import adcLinkPkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int CFG_BITS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sckIn,
  input  logic                  sdoIn,
  input  logic [CFG_BITS-1:0]   cfgWord,
  input  linkStrobe_t           strobe,
  output logic                  sckS,
  output logic                  sdoS,
  output logic                  sckRise,
  output logic                  sckFall,
  output logic                  sdiOut,
  output logic [FRAME_BITS-1:0] dataWord,
  output logic                  resultValid,
  output logic                  frameError
);

  localparam int EOC_POS  = FRAME_BITS - 1;
  localparam int ZERO_POS = FRAME_BITS - 2;

  logic [1:0] syncVec;
  logic sckPrev;
  logic [CFG_BITS-1:0] cfgShift;
  logic [FRAME_BITS-1:0] rxShift;
  logic [FRAME_BITS-1:0] fullFrame;
  logic frameOk;

  adcLinkSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({sckIn, sdoIn}),
    .resetVal(2'b00),
    .syncOut(syncVec)
  );

  assign sckS = syncVec[1];
  assign sdoS = syncVec[0];

  always_ff @(posedge clk) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign sckRise = sckS && !sckPrev;
  assign sckFall = !sckS && sckPrev;

  // configuration shifter, MSB leaves first, zeros fill behind
  always_ff @(posedge clk) begin
    if (!rstN)                 cfgShift <= '0;
    else if (strobe.loadCfg)   cfgShift <= cfgWord;
    else if (strobe.abortFrame) cfgShift <= '0;
    else if (strobe.shiftCfg)  cfgShift <= {cfgShift[CFG_BITS-2:0], 1'b0};
  end

  assign sdiOut = cfgShift[CFG_BITS-1];

  assign fullFrame = {rxShift[FRAME_BITS-2:0], sdoS};
  assign frameOk   = !fullFrame[EOC_POS] && !fullFrame[ZERO_POS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift     <= '0;
      dataWord    <= '0;
      resultValid <= 1'b0;
      frameError  <= 1'b0;
    end else begin
      resultValid <= strobe.finishFrame && frameOk;
      frameError  <= strobe.finishFrame && !frameOk;
      if (strobe.loadCfg)        rxShift <= '0;
      else if (strobe.sampleBit) rxShift <= fullFrame;
      if (strobe.finishFrame)    dataWord <= fullFrame;
    end
  end

  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCfg, strobe.sampleBit, strobe.shiftCfg, strobe.abortFrame}));

  p_valid_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && frameError));

  p_valid_fields_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (!dataWord[EOC_POS] && !dataWord[ZERO_POS]));

  p_sdi_moves_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdiOut) |-> $past(strobe.loadCfg || strobe.shiftCfg || strobe.abortFrame));

endmodule

// File: rtl/adcLinkRx.sv
module adcLinkRx
  import adcLinkPkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int CFG_BITS    = 16,
  parameter int TIMEOUT_W   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sckIn,
  input  logic                  sdoIn,
  input  logic [CFG_BITS-1:0]   cfgWord,
  input  logic [TIMEOUT_W-1:0]  timeoutLimit,
  output logic                  sdiOut,
  output logic [FRAME_BITS-1:0] dataWord,
  output logic                  resultValid,
  output logic                  frameError,
  output logic                  timeoutFlag
);

  linkStrobe_t strobe;
  logic sckS, sdoS, sckRise, sckFall;

  adcLinkCtrl #(.FRAME_BITS(FRAME_BITS), .TIMEOUT_W(TIMEOUT_W)) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .sckS(sckS),
    .sdoS(sdoS),
    .sckRise(sckRise),
    .sckFall(sckFall),
    .timeoutLimit(timeoutLimit),
    .strobe(strobe),
    .timeoutFlag(timeoutFlag)
  );

  adcLinkDatapath #(
    .FRAME_BITS(FRAME_BITS),
    .CFG_BITS(CFG_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .sckIn(sckIn),
    .sdoIn(sdoIn),
    .cfgWord(cfgWord),
    .strobe(strobe),
    .sckS(sckS),
    .sdoS(sdoS),
    .sckRise(sckRise),
    .sckFall(sckFall),
    .sdiOut(sdiOut),
    .dataWord(dataWord),
    .resultValid(resultValid),
    .frameError(frameError)
  );

endmodule

// File: tb/adcLinkRx_test.sv
`timescale 1ns/1ps
module adcLinkRx_test;

  localparam int HALF  = 8;
  localparam int CONV  = 40;
  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0;
  logic sdoIn = 1'b0;
  logic [15:0] cfgWord = 16'h0000;
  logic [15:0] timeoutLimit = 16'(LIMIT);
  logic sdiOut;
  logic [23:0] dataWord;
  logic resultValid, frameError, timeoutFlag;

  int checks = 0;
  int errors = 0;
  int validCount = 0;
  int errCount = 0;
  int toCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adcLinkRx uut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .sdoIn(sdoIn),
    .cfgWord(cfgWord), .timeoutLimit(timeoutLimit), .sdiOut(sdiOut),
    .dataWord(dataWord), .resultValid(resultValid),
    .frameError(frameError), .timeoutFlag(timeoutFlag)
  );

  always @(negedge clk) begin
    if (resultValid) validCount++;
    if (frameError)  errCount++;
    if (timeoutFlag) toCount++;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model: end-of-conversion, 24 clocked bits, then conversion
  task automatic sendFrame(input logic [23:0] f, output logic [15:0] cfgSeen);
    cfgSeen = '0;
    sckIn = 1'b0; sdoIn = 1'b0;
    waitCyc(HALF);
    sdoIn = f[23];
    waitCyc(HALF);
    for (int i = 23; i >= 0; i--) begin
      sckIn = 1'b1;
      if (i >= 8) cfgSeen[i-8] = sdiOut;
      waitCyc(HALF);
      if (i > 0) begin
        sckIn = 1'b0;
        sdoIn = f[i-1];
        waitCyc(HALF);
      end
    end
    sdoIn = 1'b1;
    waitCyc(CONV);
  endtask

  task automatic goodFrame(input logic [23:0] f, input logic [15:0] cfg, input string req);
    logic [15:0] seen;
    int v0, e0;
    cfgWord = cfg;
    v0 = validCount; e0 = errCount;
    sendFrame(f, seen);
    check(validCount == v0 + 1, req, "valid pulses", validCount - v0, 1);
    check(errCount == e0, "R5", "error pulses on good frame", errCount - e0, 0);
    check(dataWord == f, req, "dataWord", dataWord, f);
    check(seen == cfg, "R3", "config bits seen", seen, cfg);
    check(sdiOut == 1'b0, "R3", "sdiOut during conversion", sdiOut, 0);
  endtask

  task automatic badFrame(input logic [23:0] f);
    logic [15:0] seen;
    int v0, e0;
    v0 = validCount; e0 = errCount;
    sendFrame(f, seen);
    check(errCount == e0 + 1, "R5", "error pulses", errCount - e0, 1);
    check(validCount == v0, "R5", "valid on bad frame", validCount - v0, 0);
    check(dataWord == f, "R4", "dataWord on bad frame", dataWord, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] seen;
    logic [31:0] lcg;
    int v0, t0;

    // R1: reset state
    cfgWord = 16'h8001;
    waitCyc(5);
    check(dataWord == 24'h0, "R1", "dataWord in reset", dataWord, 0);
    check({resultValid, frameError, timeoutFlag} == 3'b0, "R1", "strobes in reset",
          {resultValid, frameError, timeoutFlag}, 0);
    check(sdiOut == 1'b0, "R1", "sdiOut in reset", sdiOut, 0);
    rstN = 1'b1;
    waitCyc(1);
    check(sdiOut == 1'b0 && dataWord == 24'h0, "R1", "after reset", {sdiOut, dataWord}, 0);

    // R8: low-low lines before the link was seen idle start nothing
    waitCyc(30);
    check(sdiOut == 1'b0, "R8", "sdiOut with lines low after reset", sdiOut, 0);
    check(validCount + errCount == 0, "R8", "frames before idle", validCount + errCount, 0);
    sckIn = 1'b1; sdoIn = 1'b1;
    waitCyc(CONV);

    // R2: frame start presents the configuration MSB
    cfgWord = 16'h8000;
    sckIn = 1'b0; sdoIn = 1'b0;
    waitCyc(HALF);
    check(sdiOut == 1'b1, "R2", "sdiOut at frame start", sdiOut, 1);
    for (int i = 23; i >= 0; i--) begin
      sckIn = 1'b1; waitCyc(HALF);
      if (i > 0) begin sckIn = 1'b0; sdoIn = 1'b0; waitCyc(HALF); end
    end
    sdoIn = 1'b1;
    waitCyc(CONV);
    check(dataWord == 24'h0 && validCount == 1, "R4", "all-zero frame", dataWord, 0);

    // R4: walking one through every payload bit
    for (int k = 0; k < 22; k++)
      goodFrame(24'(1) << k, 16'hA5C3 ^ 16'(k * 16'h0111), "R4");
    goodFrame(24'h3FFFFF, 16'hFFFF, "R4");
    goodFrame(24'h2AAAAA, 16'h5555, "R4");
    lcg = 32'h1234_5678;
    for (int k = 0; k < 8; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      goodFrame({2'b00, lcg[29:8]}, lcg[31:16], "R4");
    end

    // R5: flag-bit errors
    badFrame(24'h400000 | 24'h001234);
    badFrame(24'h800000 | 24'h00ABCD);
    badFrame(24'hC00000);
    goodFrame(24'h155555, 16'h0F0F, "R5");

    // R6: configuration change during a frame
    cfgWord = 16'hC3A5;
    fork
      sendFrame(24'h012345, seen);
      begin waitCyc(100); cfgWord = 16'h1E2D; end
    join
    check(seen == 16'hC3A5, "R6", "config latched at frame start", seen, 16'hC3A5);
    goodFrame(24'h054321, 16'h1E2D, "R6");

    // R7: no timeout during normal frames
    check(toCount == 0, "R7", "timeouts in normal frames", toCount, 0);

    // R7: stalled frame
    v0 = validCount; t0 = toCount;
    cfgWord = 16'hFFFF;
    sckIn = 1'b0; sdoIn = 1'b0;
    waitCyc(HALF);
    for (int i = 0; i < 5; i++) begin
      sckIn = 1'b1; waitCyc(HALF);
      sckIn = 1'b0; waitCyc(HALF);
    end
    waitCyc(LIMIT + 20);
    check(toCount == t0 + 1, "R7", "timeout pulses", toCount - t0, 1);
    check(validCount == v0, "R7", "valid on stalled frame", validCount - v0, 0);
    check(sdiOut == 1'b0, "R7", "sdiOut after abort", sdiOut, 0);
    // R8: after a timeout, lines still low start nothing
    waitCyc(30);
    check(sdiOut == 1'b0, "R8", "sdiOut while waiting for idle", sdiOut, 0);
    sckIn = 1'b1; sdoIn = 1'b1;
    waitCyc(CONV);
    goodFrame(24'h2BCDEF, 16'h7E81, "R7");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule